// File: doc/BRIEF.md
# Ball-Beam Physics Stepper with Survival Timer

This block is a stepped integer model of a ball rolling on a curved beam whose tilt a stepper motor sets. Every enabled clock stands for one millisecond of simulated time. In that one clock it does three things in order. It moves the beam one motor pulse in the direction the controller asks for. It advances the ball velocity and then the ball position with shift-only fixed-point arithmetic. It presents the new state to the controller as a 32-bit word with exactly one bit set in each of three fields.

A survival counter counts the simulated milliseconds. The run ends when the ball hits an end-stop or when the counter reaches the time limit. From then on the counter and the state stay frozen until reset. The controller under evaluation reads the state word and drives the motor direction. An evolution engine reads the counter as the fitness once the done flag is high. The clock enable lets the engine pause the run or step it slowly.

Top module: `ballbeam_sim`

## Requirements
- R1: A synchronous active-low reset sets the fitness to 0 and clears done. It puts the ball at -180000 (left side), its velocity at 0 and the beam at +90 pulses (about 20 degrees), so the state word reads 32'h4010_0001.
- R2: On each active tick the beam moves one pulse: up when motor_dir is 1, down when it is 0. It saturates at +135 and -135 pulses.
- R3: On each active tick, after the beam update: accel = (x >>> 4) + 200*beam, v = v + (accel >>> 4), x = x + (v >>> 6). All values are signed 32-bit integers scaled by 10000, and none overflows.
- R4: state_word[18:0] is the ball field. Bit k is set, where k = (x + 190000) / 20000, clamped to 0..18.
- R5: state_word[21:19] is the speed field. Bit 19 means moving left (v < -2000). Bit 21 means moving right (v > 2000). Bit 20 means near stationary.
- R6: state_word[31:22] is the beam field. Bit 22+j is set, where j = (beam + 135) / 27, clamped to 0..9.
- R7: The fitness counter increases by exactly one on each active tick and starts from 0 after reset.
- R8: When the new position reaches +190000 or -190000 or goes past it, x is clamped to that end-stop and done is set on the same tick.
- R9: When the fitness reaches FIT_LIMIT (300000 by default), done is set on that tick.
- R10: Once done is high, the fitness, the ball, the beam and done itself hold until reset.
- R11: While step_en is low, the fitness and the state word do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one active tick is 1 ms of simulated time |
| rst_n | input | 1 | Synchronous active-low reset to the start position |
| step_en | input | 1 | Clock enable; the model advances only when high |
| motor_dir | input | 1 | Requested motor direction: 1 tilts up, 0 tilts down |
| state_word | output | 32 | One-hot ball, speed and beam fields |
| fitness | output | 32 | Count of simulated milliseconds survived |
| done | output | 1 | Run finished: end-stop reached or time limit met |

## Verification
The bench keeps its own model of the physics and bins. It goes after four corner cases.

- **Beam saturation.** The bench drives the motor the same way for long enough that the beam must pin at +135 and then at -135. A design that wraps or keeps counting would show the wrong beam field and bend the ball path.
- **End-stop contact.** The bench checks done and the clamped position on the exact tick of contact. A design that is one tick late or fails to clamp would show an off-by-one fitness or a ball bin past the edge.
- **Time limit.** A second instance with a short limit proves done rises exactly when the count reaches the limit.
- **Frozen states.** The bench checks the paused and finished states. A counter that keeps running there would show up at once in the fitness readout.

// File: rtl/bb_pkg.sv
// Shared types for the ball-beam stepper.
// Assumes every physical quantity fits a signed 32-bit integer scaled by 10000.
package bb_pkg;
    typedef logic signed [31:0] fx_t;

    typedef enum logic [1:0] {
        SPD_LEFT  = 2'd0,
        SPD_STILL = 2'd1,
        SPD_RIGHT = 2'd2
    } speed_e;
endpackage

// File: rtl/bb_beam_axis.sv
// Beam tilt in motor pulses: one pulse per active tick toward motor_dir,
// saturating at +/-BEAM_MAX. Assumes BEAM_INIT lies inside the range.
module bb_beam_axis
    import bb_pkg::*;
#(
    parameter int BEAM_MAX  = 135,
    parameter int BEAM_INIT = 90
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic motor_dir,
    output fx_t  beam_q,
    output fx_t  beam_next
);
    localparam fx_t HI = fx_t'(BEAM_MAX);
    localparam fx_t LO = -fx_t'(BEAM_MAX);

    // Next pulse count with saturation at both limits.
    always_comb begin
        if (motor_dir)
            beam_next = (beam_q >= HI) ? HI : beam_q + 32'sd1;
        else
            beam_next = (beam_q <= LO) ? LO : beam_q - 32'sd1;
    end

    // Beam register, loaded only on active ticks.
    always_ff @(posedge clk) begin
        if (!rst_n)
            beam_q <= fx_t'(BEAM_INIT);
        else if (run)
            beam_q <= beam_next;
    end

    // R2: the beam never leaves its travel range.
    p_beam_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (beam_q <= HI) && (beam_q >= LO));

    // R2: an active tick moves the beam by at most one pulse, toward the request.
    p_beam_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> ($past(motor_dir) ? (beam_q - $past(beam_q)) inside {32'sd0, 32'sd1}
                                  : ($past(beam_q) - beam_q) inside {32'sd0, 32'sd1}));
endmodule

// File: rtl/bb_ball_dynamics.sv
// Ball velocity and position update with shift-only scaling and end-stop
// clamping. Assumes the beam value given is the one already stepped this tick.
module bb_ball_dynamics
    import bb_pkg::*;
#(
    parameter int X_END   = 190000,
    parameter int X_START = 180000,
    parameter int K_BEAM  = 200,
    parameter int SH_POS  = 4,
    parameter int SH_VEL  = 4,
    parameter int SH_X    = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  fx_t  beam_next,
    output fx_t  x_q,
    output fx_t  v_q,
    output logic hit
);
    localparam fx_t XE = fx_t'(X_END);
    localparam fx_t LIM_V = fx_t'(32'sh4000_0000);

    fx_t accel, v_next, x_raw, x_next;

    // One Euler step: acceleration, then velocity, then position with clamp.
    always_comb begin
        accel  = (x_q >>> SH_POS) + beam_next * fx_t'(K_BEAM);
        v_next = v_q + (accel >>> SH_VEL);
        x_raw  = x_q + (v_next >>> SH_X);
        hit    = 1'b0;
        x_next = x_raw;
        if (x_raw >= XE) begin
            x_next = XE;
            hit    = 1'b1;
        end else if (x_raw <= -XE) begin
            x_next = -XE;
            hit    = 1'b1;
        end
    end

    // Ball state registers, starting on the left side at rest.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q <= -fx_t'(X_START);
            v_q <= '0;
        end else if (run) begin
            x_q <= x_next;
            v_q <= v_next;
        end
    end

    // R3: velocity stays far from the 32-bit limit.
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (v_q < LIM_V) && (v_q > -LIM_V));

    // R8: the ball never sits beyond an end-stop.
    p_x_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (x_q <= XE) && (x_q >= -XE));
endmodule

// File: rtl/bb_state_encoder.sv
// Builds the controller word from the numeric state: ball bins, speed class
// and beam bins, each field one-hot. Assumes the ranges divide evenly.
module bb_state_encoder
    import bb_pkg::*;
#(
    parameter int N_BALL     = 19,
    parameter int N_BEAM     = 10,
    parameter int X_END      = 190000,
    parameter int BEAM_MAX   = 135,
    parameter int V_DEADBAND = 2000,
    localparam int WORD_W    = N_BALL + 3 + N_BEAM
) (
    input  logic              clk,
    input  logic              rst_n,
    input  fx_t               x,
    input  fx_t               v,
    input  fx_t               beam,
    output logic [WORD_W-1:0] word
);
    localparam int BALL_W = (2 * X_END) / N_BALL;
    localparam int BEAM_W = (2 * BEAM_MAX) / N_BEAM;

    logic [N_BALL-1:0] ball_f;
    logic [N_BEAM-1:0] beam_f;
    logic [2:0]        spd_f;
    speed_e            spd;

    // Ball bins: each bit tests its own window; the edge bins are open-ended.
    for (genvar i = 0; i < N_BALL; i++) begin : g_ball
        localparam fx_t LO = fx_t'(-X_END + i * BALL_W);
        localparam fx_t HI = fx_t'(-X_END + (i + 1) * BALL_W);
        assign ball_f[i] = ((i == 0) || (x >= LO)) && ((i == N_BALL - 1) || (x < HI));
    end

    // Beam bins, built the same way over the pulse range.
    for (genvar j = 0; j < N_BEAM; j++) begin : g_beam
        localparam fx_t LO = fx_t'(-BEAM_MAX + j * BEAM_W);
        localparam fx_t HI = fx_t'(-BEAM_MAX + (j + 1) * BEAM_W);
        assign beam_f[j] = ((j == 0) || (beam >= LO)) && ((j == N_BEAM - 1) || (beam < HI));
    end

    // Speed class from the velocity deadband.
    always_comb begin
        if (v < -fx_t'(V_DEADBAND))     spd = SPD_LEFT;
        else if (v > fx_t'(V_DEADBAND)) spd = SPD_RIGHT;
        else                            spd = SPD_STILL;
        spd_f = 3'b001 << spd;
    end

    assign word = {beam_f, spd_f, ball_f};

    // R4: exactly one ball bin is active.
    p_ball_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(word[N_BALL-1:0]) == 1);
    // R5: exactly one speed class is active.
    p_speed_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(word[N_BALL+2:N_BALL]) == 1);
    // R6: exactly one beam bin is active.
    p_beam_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(word[WORD_W-1:N_BALL+3]) == 1);
endmodule

// File: rtl/bb_fitness.sv
// Survival counter and run-finished flag. Counts active ticks and ends the run
// on an end-stop hit or at the time limit. Assumes FIT_LIMIT >= 1.
module bb_fitness #(
    parameter int FIT_LIMIT = 300000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        run,
    input  logic        hit,
    output logic [31:0] count,
    output logic        done
);
    localparam logic [31:0] LIMIT = 32'(FIT_LIMIT);

    // Counter and sticky done flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            done  <= 1'b0;
        end else if (run) begin
            count <= count + 32'd1;
            done  <= hit || (count + 32'd1 == LIMIT);
        end
    end

    // R7: every active tick adds exactly one.
    p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> count == $past(count) + 32'd1);
    // R10: once finished, the count and the flag stay put.
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (done && $stable(count)));
    // R9: the counter never passes the limit.
    p_limit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        count <= LIMIT);
endmodule

// File: rtl/ballbeam_sim.sv
// Top of the ball-beam stepper. One active tick = 1 ms: beam step, ball
// update, state encode, fitness count. Assumes motor_dir is stable at the edge.
module ballbeam_sim
    import bb_pkg::*;
#(
    parameter int N_BALL     = 19,
    parameter int N_BEAM     = 10,
    parameter int X_END      = 190000,
    parameter int X_START    = 180000,
    parameter int BEAM_MAX   = 135,
    parameter int BEAM_INIT  = 90,
    parameter int K_BEAM     = 200,
    parameter int SH_POS     = 4,
    parameter int SH_VEL     = 4,
    parameter int SH_X       = 6,
    parameter int V_DEADBAND = 2000,
    parameter int FIT_LIMIT  = 300000,
    localparam int WORD_W    = N_BALL + 3 + N_BEAM
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_en,
    input  logic              motor_dir,
    output logic [WORD_W-1:0] state_word,
    output logic [31:0]       fitness,
    output logic              done
);
    fx_t  beam_q, beam_next, x_q, v_q;
    logic hit, run;

    // A tick advances the model only while enabled and not finished.
    assign run = step_en && !done;

    bb_beam_axis #(.BEAM_MAX(BEAM_MAX), .BEAM_INIT(BEAM_INIT)) u_beam (
        .clk(clk), .rst_n(rst_n), .run(run), .motor_dir(motor_dir),
        .beam_q(beam_q), .beam_next(beam_next)
    );

    bb_ball_dynamics #(
        .X_END(X_END), .X_START(X_START), .K_BEAM(K_BEAM),
        .SH_POS(SH_POS), .SH_VEL(SH_VEL), .SH_X(SH_X)
    ) u_dyn (
        .clk(clk), .rst_n(rst_n), .run(run), .beam_next(beam_next),
        .x_q(x_q), .v_q(v_q), .hit(hit)
    );

    bb_state_encoder #(
        .N_BALL(N_BALL), .N_BEAM(N_BEAM), .X_END(X_END),
        .BEAM_MAX(BEAM_MAX), .V_DEADBAND(V_DEADBAND)
    ) u_enc (
        .clk(clk), .rst_n(rst_n), .x(x_q), .v(v_q), .beam(beam_q),
        .word(state_word)
    );

    bb_fitness #(.FIT_LIMIT(FIT_LIMIT)) u_fit (
        .clk(clk), .rst_n(rst_n), .run(run), .hit(hit),
        .count(fitness), .done(done)
    );

    // R11: a paused tick leaves the outputs untouched.
    p_pause_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> ($stable(state_word) && $stable(fitness)));
    // R10: a finished run keeps its state word.
    p_done_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> $stable(state_word));
endmodule

// File: tb/tb_ballbeam_sim.sv
`timescale 1ns/1ps
module tb_ballbeam_sim;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_en = 1'b0;
    logic        motor_dir = 1'b0;
    logic [31:0] state_word, state_lim, fitness, fit_lim;
    logic        done, done_lim;

    int errors = 0;
    int checks = 0;

    // reference model state
    int m_beam, m_v, m_x, m_fit;
    bit m_done;

    localparam int LIM_SHORT = 25;

    always #5 clk = ~clk;

    ballbeam_sim dut (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .motor_dir(motor_dir),
        .state_word(state_word), .fitness(fitness), .done(done)
    );

    ballbeam_sim #(.FIT_LIMIT(LIM_SHORT)) dut_lim (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .motor_dir(motor_dir),
        .state_word(state_lim), .fitness(fit_lim), .done(done_lim)
    );

    typedef struct packed {
        logic        en;
        logic        dir;
        logic [15:0] n;
    } vec_t;

    localparam vec_t VEC [7] = '{
        '{1'b1, 1'b1, 16'd40},
        '{1'b0, 1'b1, 16'd10},
        '{1'b1, 1'b0, 16'd60},
        '{1'b1, 1'b1, 16'd30},
        '{1'b0, 1'b0, 16'd5},
        '{1'b1, 1'b0, 16'd20},
        '{1'b1, 1'b0, 16'd400}
    };

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(input int x, input int v, input int b);
        logic [31:0] w = '0;
        int bb = (x + 190000) / 20000;
        int gb = (b + 135) / 27;
        if (bb > 18) bb = 18;
        if (bb < 0) bb = 0;
        if (gb > 9) gb = 9;
        if (gb < 0) gb = 0;
        w[bb] = 1'b1;
        if (v < -2000)     w[19] = 1'b1;
        else if (v > 2000) w[21] = 1'b1;
        else               w[20] = 1'b1;
        w[22 + gb] = 1'b1;
        return w;
    endfunction

    task automatic model_reset();
        m_beam = 90; m_v = 0; m_x = -180000; m_fit = 0; m_done = 0;
    endtask

    task automatic model_step(input bit en, input bit dir);
        int a, xr;
        if (!en || m_done) return;
        if (dir) m_beam = (m_beam >= 135) ? 135 : m_beam + 1;
        else     m_beam = (m_beam <= -135) ? -135 : m_beam - 1;
        a   = (m_x >>> 4) + 200 * m_beam;
        m_v = m_v + (a >>> 4);
        xr  = m_x + (m_v >>> 6);
        m_fit++;
        if (xr >= 190000)       begin m_x = 190000;  m_done = 1; end
        else if (xr <= -190000) begin m_x = -190000; m_done = 1; end
        else m_x = xr;
        if (m_fit == 300000) m_done = 1;
    endtask

    task automatic compare_all(input string tag);
        logic [31:0] ew = exp_word(m_x, m_v, m_beam);
        check(state_word === ew, {tag, " R3 R4 R5 R6 state word"}, state_word, ew);
        check(fitness === 32'(m_fit), {tag, " R7 fitness"}, fitness, 32'(m_fit));
        check(done === m_done, {tag, " R8 done"}, {31'd0, done}, {31'd0, m_done});
    endtask

    // one tick: drive at a falling edge, then compare at the next falling edge
    task automatic tick(input bit en, input bit dir, input string tag);
        step_en = en;
        motor_dir = dir;
        model_step(en, dir);
        @(negedge clk);
        compare_all(tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        step_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual=%0d expected=0", checks);
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        // R1: reset values
        do_reset();
        check(state_word === 32'h4010_0001, "R1 reset word", state_word, 32'h4010_0001);
        check(fitness === 32'd0, "R1 reset fitness", fitness, 32'd0);
        check(done === 1'b0, "R1 reset done", {31'd0, done}, 32'd0);

        // vector table walk: R2, R3 to R8, R11 pause phases
        foreach (VEC[p]) begin
            for (int t = 0; t < int'(VEC[p].n); t++)
                tick(VEC[p].en, VEC[p].dir, VEC[p].en ? "table" : "R11 pause");
        end

        // R2: beam pins at +135 while the ball runs right to the end-stop (R8)
        do_reset();
        for (int t = 0; t < 3000 && !m_done; t++) tick(1'b1, 1'b1, "R2 saturate up");
        check(state_word[31] === 1'b1, "R2 beam field at top", state_word, 32'h8000_0000);
        check(done === 1'b1, "R8 end-stop reached", {31'd0, done}, 32'd1);
        check(state_word[18] === 1'b1, "R8 ball clamped right bin", state_word, 32'h0004_0000);

        // R10: further enabled ticks change nothing
        for (int t = 0; t < 20; t++) tick(1'b1, 1'b0, "R10 hold after done");

        // R9: short-limit instance finishes exactly at its limit
        do_reset();
        for (int t = 1; t <= 30; t++) begin
            tick(1'b1, 1'b1, "R9 timer run");
            check(fit_lim === 32'((t < LIM_SHORT) ? t : LIM_SHORT), "R9 limited fitness",
                  fit_lim, 32'((t < LIM_SHORT) ? t : LIM_SHORT));
            check(done_lim === (t >= LIM_SHORT), "R9 limited done",
                  {31'd0, done_lim}, {31'd0, t >= LIM_SHORT});
        end

        // R1: reset in mid-run returns to start
        do_reset();
        check(state_word === 32'h4010_0001, "R1 re-reset word", state_word, 32'h4010_0001);
        check(fitness === 32'd0, "R1 re-reset fitness", fitness, 32'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule